// File: doc/BRIEF.md
# Timing Pulse and Interval Timer

This block drives one open-drain timing-pulse pin from a 32.768 kHz clock. A free-running binary prescaler supplies fixed square-wave taps. An independent interval counter produces a periodic 50% duty signal with a period of 1, 10, 30 or 60 seconds. The command decoder upstream delivers one strobed 4-bit code per command. A flag on the strobe says whether the code is a 3-bit pin-style command or a 4-bit serially loaded command.

Pin-style commands select a fixed pattern, and each one halts the interval counter. For the four register-control codes, that pattern follows the register mode that was requested. Serially loaded commands select any of four fixed frequencies. They can also program and start the interval counter, clear its output flag, restart it or freeze it.

The interval counter counts 64 Hz ticks taken from the prescaler. It has no link to the calendar counter, so its resolution is 1/64 s. The pin is modelled as an active-low pull-down enable: a 1 releases the pin (high level) and a 0 pulls it low.

Top module: `tpulse_gen`

## Requirements
- R1: While reset is held, and right after it ends, the prescaler holds zero, the 64 Hz tap drives the output, the interval counter is stopped and its flag is clear.
- R2: The prescaler is a 10-bit counter that advances by one on every clock edge. A fixed selection drives `tp_oe_n` with one prescaler bit: 4096 Hz is bit 2, 2048 Hz is bit 3, 256 Hz is bit 6, 64 Hz is bit 8 and 32 Hz is bit 9.
- R3: Serial codes 4, 5, 6 and 7 select 64, 256, 2048 and 4096 Hz. Each one halts the interval counter and keeps its flag.
- R4: Pin-style codes (the low 3 bits of `cmd`) give these outputs: 0 gives 64 Hz, 1 gives 32 Hz, 2 holds the pin low, 3 gives 32 Hz, 4 gives 64 Hz, 5 gives 256 Hz and 6 gives 2048 Hz. Each of these halts the interval counter.
- R5: Serial codes 8, 9, 10 and 11 choose a period of 1, 10, 30 or 60 seconds. The command clears the counter and the flag, starts counting and routes the flag to the pin. The output is low for the first half of each period and high for the second half.
- R6: A tick occurs on an edge where the low 9 prescaler bits were all ones before the edge. A running counter advances on each tick. The flag sets when the count reaches half the period. The flag clears, and the count returns to zero, when the count reaches the full period. `TICKS_PER_SEC` ticks make one second.
- R7: Serial code 12 clears the flag and the counter keeps counting. If it lands on the tick that would set the flag, the flag stays low and the counter still advances.
- R8: Serial code 13 clears the counter, starts it and routes the flag to the pin. The flag keeps its value.
- R9: Serial code 14 freezes the counter, and the output level stays unchanged.
- R10: Serial codes 0 to 3, serial code 15 and pin-style code 7 change neither the output nor the interval counter.
- R11: Pin-style code 0 restores the 64 Hz output from any state, including after serial code 15.
- R12: A command takes effect on the edge where it is strobed. On that edge the tick does not advance the counter if the command is a set, a run, a stop or a pattern selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_ser | input | 1 | 1: serially loaded 4-bit code, 0: pin-style 3-bit code |
| cmd | input | 4 | Command code |
| tp_oe_n | output | 1 | Active-low pull-down enable of the timing-pulse pin (1 = released/high) |

## Verification
A serial command and a 64 Hz tick can act on the same edge. The sharpest case is a flag clear that arrives on the tick which would raise the flag: the clear must win while the count still advances. The bench aligns its strobe to that exact edge by counting clock edges from reset. It then expects the pin to stay low for the rest of that period and to rise again exactly one period later. A stop landing on a tick edge is provoked in the same way, and the pin is judged to stay low long after that edge.

// File: rtl/tpulse_gen.sv
module tpulse_gen #(
  parameter int OSC_LOG2      = 15,
  parameter int TICKS_PER_SEC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb,
  input  logic       cmd_ser,
  input  logic [3:0] cmd,
  output logic       tp_oe_n
);
  localparam int PRE_W  = OSC_LOG2 - 5;
  localparam int TICK_W = OSC_LOG2 - 6;
  localparam int T4K    = OSC_LOG2 - 13;
  localparam int T2K    = OSC_LOG2 - 12;
  localparam int T256   = OSC_LOG2 - 9;
  localparam int T64    = OSC_LOG2 - 7;
  localparam int T32    = OSC_LOG2 - 6;
  localparam int CNT_W  = $clog2(60 * TICKS_PER_SEC + 1);
  localparam int HW     = CNT_W - 1;

  typedef enum logic [2:0] {
    SRC_64, SRC_32, SRC_256, SRC_2K, SRC_4K, SRC_LOW, SRC_IVL
  } src_t;

  logic [PRE_W-1:0] div;
  src_t             src;
  logic             ivl_run, ivl_flag;
  logic [CNT_W-1:0] ivl_cnt, nxt;
  logic [HW-1:0]    ivl_half, new_half;
  logic             lvl;

  wire par      = cmd_stb && !cmd_ser;
  wire ser      = cmd_stb && cmd_ser;
  wire par_act  = par && (cmd[2:0] != 3'd7);
  wire ser_fix  = ser && (cmd[3:2] == 2'b01);
  wire ser_set  = ser && (cmd[3:2] == 2'b10);
  wire ser_clr  = ser && (cmd == 4'd12);
  wire ser_run  = ser && (cmd == 4'd13);
  wire ser_stop = ser && (cmd == 4'd14);
  wire tick     = &div[TICK_W-1:0];
  wire adv      = ivl_run && tick && !(par_act || ser_fix || ser_set || ser_run || ser_stop);

  assign nxt = ivl_cnt + 1'b1;

  always_comb begin
    case (cmd[1:0])
      2'd0:    new_half = HW'(TICKS_PER_SEC / 2);
      2'd1:    new_half = HW'(10 * TICKS_PER_SEC / 2);
      2'd2:    new_half = HW'(30 * TICKS_PER_SEC / 2);
      default: new_half = HW'(60 * TICKS_PER_SEC / 2);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= SRC_64;
    end else if (par_act) begin
      case (cmd[2:0])
        3'd0, 3'd4: src <= SRC_64;
        3'd1, 3'd3: src <= SRC_32;
        3'd2:       src <= SRC_LOW;
        3'd5:       src <= SRC_256;
        default:    src <= SRC_2K;
      endcase
    end else if (ser_fix) begin
      case (cmd[1:0])
        2'd0:    src <= SRC_64;
        2'd1:    src <= SRC_256;
        2'd2:    src <= SRC_2K;
        default: src <= SRC_4K;
      endcase
    end else if (ser_set || ser_run) begin
      src <= SRC_IVL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_run  <= 1'b0;
      ivl_cnt  <= '0;
      ivl_flag <= 1'b0;
      ivl_half <= HW'(TICKS_PER_SEC / 2);
    end else begin
      if (par_act || ser_fix || ser_stop) ivl_run <= 1'b0;
      else if (ser_set || ser_run)        ivl_run <= 1'b1;

      if (ser_set) ivl_half <= new_half;

      if (ser_set || ser_run) ivl_cnt <= '0;
      else if (adv)           ivl_cnt <= (nxt == {ivl_half, 1'b0}) ? '0 : nxt;

      if (ser_set || ser_clr) ivl_flag <= 1'b0;
      else if (adv) begin
        if (nxt == {1'b0, ivl_half})      ivl_flag <= 1'b1;
        else if (nxt == {ivl_half, 1'b0}) ivl_flag <= 1'b0;
      end
    end
  end

  always_comb begin
    case (src)
      SRC_64:  lvl = div[T64];
      SRC_32:  lvl = div[T32];
      SRC_256: lvl = div[T256];
      SRC_2K:  lvl = div[T2K];
      SRC_4K:  lvl = div[T4K];
      SRC_IVL: lvl = ivl_flag;
      default: lvl = 1'b0;
    endcase
  end

  assign tp_oe_n = lvl;
endmodule

// File: rtl/tpulse_gen_chk.sv
module tpulse_gen_chk #(
  parameter int PRE_W = 10,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_stb,
  input logic             cmd_ser,
  input logic [3:0]       cmd,
  input logic             tp_oe_n,
  input logic [PRE_W-1:0] div,
  input logic [2:0]       src,
  input logic             ivl_run,
  input logic             ivl_flag,
  input logic [CNT_W-1:0] ivl_cnt,
  input logic [CNT_W-2:0] ivl_half
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_cnt < {ivl_half, 1'b0});

  // R5
  set_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_ser && cmd[3:2] == 2'b10) |=> (ivl_cnt == '0 && !ivl_flag && ivl_run));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_ser && cmd == 4'd12 && src == 3'd6) |=> !tp_oe_n);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ivl_run && !cmd_stb) |=> ($stable(ivl_cnt) && $stable(ivl_flag)));

  // R4
  time_set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_ser && cmd[2:0] == 3'd2) |=> !tp_oe_n);

  // R3
  fix_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_ser && cmd[3:2] == 2'b01) |=> !ivl_run);

  // R11
  hold_64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_ser && cmd[2:0] == 3'd0) |=> (tp_oe_n == div[PRE_W-2]));
endmodule

bind tpulse_gen tpulse_gen_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_ser(cmd_ser), .cmd(cmd),
  .tp_oe_n(tp_oe_n), .div(div), .src(src), .ivl_run(ivl_run),
  .ivl_flag(ivl_flag), .ivl_cnt(ivl_cnt), .ivl_half(ivl_half)
);

// File: tb/tpulse_gen_bench.sv
module tpulse_gen_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_stb = 1'b0;
  logic       cmd_ser = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic       tp_oe_n;
  int         edges = 0;
  int         checks = 0;
  int         fails = 0;

  always #(CLK_P / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  tpulse_gen #(.TICKS_PER_SEC(2)) u_tpulse_gen (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_ser(cmd_ser),
    .cmd(cmd), .tp_oe_n(tp_oe_n)
  );

  function automatic logic tap(input int e, input int k);
    return logic'(((e % 1024) >> k) & 1);
  endfunction

  function automatic logic exp_fix(input logic s, input logic [3:0] c, input int e);
    if (!s) begin
      case (c[2:0])
        3'd0, 3'd4: return tap(e, 8);
        3'd1, 3'd3: return tap(e, 9);
        3'd5:       return tap(e, 6);
        3'd6:       return tap(e, 3);
        default:    return 1'b0;
      endcase
    end
    case (c[1:0])
      2'd0:    return tap(e, 8);
      2'd1:    return tap(e, 6);
      2'd2:    return tap(e, 3);
      default: return tap(e, 2);
    endcase
  endfunction

  function automatic int next_tick(input int e);
    return (e / 512 + 1) * 512;
  endfunction

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (tp_oe_n !== exp) begin
      fails++;
      $display("FAIL %s: tp_oe_n=%0b expected %0b (edge %0d)", tag, tp_oe_n, exp, edges);
    end
  endtask

  task automatic send(input logic s, input logic [3:0] c);
    cmd_ser = s; cmd = c; cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic wait_to(input int v);
    while (edges < v) @(negedge clk);
  endtask

  task automatic align();
    while (edges % 512 != 100) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int e, t1;
    void'($urandom(32'd4990));
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    wait_to(200); chk(tap(edges, 8), "R1 64Hz after reset");
    wait_to(300); chk(tap(edges, 8), "R1 64Hz after reset");

    // R2 R3 R4: random fixed selections
    for (int i = 0; i < 30; i++) begin
      int r = $urandom % 11;
      logic s = (r >= 7);
      logic [3:0] c = s ? 4'(r - 3) : 4'(r);
      send(s, c);
      chk(exp_fix(s, c, edges), "R4/R3 right after command");
      repeat ($urandom % 1200 + 1) @(negedge clk);
      chk(exp_fix(s, c, edges), "R2/R4/R3 random sample");
      repeat ($urandom % 7 + 1) @(negedge clk);
      chk(exp_fix(s, c, edges), "R2 random sample");
    end
    send(0, 4'd2); repeat (700) @(negedge clk); chk(1'b0, "R4 time-set low");
    send(0, 4'd1); repeat (300) @(negedge clk); chk(tap(edges, 9), "R4 shift 32Hz");

    // R5 R6: 1 s interval
    align(); send(1, 4'd8); t1 = next_tick(edges);
    chk(1'b0, "R5 set clears flag");
    wait_to(t1 - 1);    chk(1'b0, "R5 first half low");
    wait_to(t1);        chk(1'b1, "R6 rise at half");
    wait_to(t1 + 511);  chk(1'b1, "R6 high second half");
    wait_to(t1 + 512);  chk(1'b0, "R6 fall at period");
    wait_to(t1 + 1024); chk(1'b1, "R6 periodic rise");

    // R5: 10 s
    align(); send(1, 4'd9); t1 = next_tick(edges);
    wait_to(t1 + 9 * 512 - 1);  chk(1'b0, "R5 10s low");
    wait_to(t1 + 9 * 512);      chk(1'b1, "R5 10s rise");
    wait_to(t1 + 19 * 512 - 1); chk(1'b1, "R5 10s high");
    wait_to(t1 + 19 * 512);     chk(1'b0, "R5 10s fall");
    // R5: 30 s and 60 s
    align(); send(1, 4'd10); t1 = next_tick(edges);
    wait_to(t1 + 29 * 512 - 1); chk(1'b0, "R5 30s low");
    wait_to(t1 + 29 * 512);     chk(1'b1, "R5 30s rise");
    align(); send(1, 4'd11); t1 = next_tick(edges);
    wait_to(t1 + 59 * 512 - 1); chk(1'b0, "R5 60s low");
    wait_to(t1 + 59 * 512);     chk(1'b1, "R5 60s rise");

    // R7: flag clear while counter runs
    align(); send(1, 4'd8); t1 = next_tick(edges);
    wait_to(t1 + 100); chk(1'b1, "R7 flag high before clear");
    send(1, 4'd12);    chk(1'b0, "R7 cleared");
    wait_to(t1 + 1023); chk(1'b0, "R7 stays low");
    wait_to(t1 + 1024); chk(1'b1, "R7 counter kept running");

    // R7 R12: clear on the rising tick edge
    align(); send(1, 4'd8); t1 = next_tick(edges);
    wait_to(t1 - 1); send(1, 4'd12);
    chk(1'b0, "R7 clear wins on tick edge");
    wait_to(t1 + 512);  chk(1'b0, "R7 low through period");
    wait_to(t1 + 1024); chk(1'b1, "R7 R12 count advanced on clear edge");

    // R9 R8: stop while high, then run
    align(); send(1, 4'd8); t1 = next_tick(edges);
    wait_to(t1 + 50); send(1, 4'd14);
    repeat (2000) @(negedge clk); chk(1'b1, "R9 frozen high");
    send(1, 4'd13); chk(1'b1, "R8 run keeps flag");
    e = next_tick(edges);
    wait_to(e + 511); chk(1'b1, "R8 high until period end");
    wait_to(e + 512); chk(1'b0, "R8 restarted count falls");

    // R9 R12: stop on the tick edge while low
    align(); send(1, 4'd8); t1 = next_tick(edges);
    wait_to(t1 - 1); send(1, 4'd14);
    repeat (3000) @(negedge clk); chk(1'b0, "R9 R12 stop on tick edge stays low");

    // R3: fixed selection halts timer and keeps flag
    align(); send(1, 4'd8); t1 = next_tick(edges);
    wait_to(t1 + 10); send(1, 4'd7);
    repeat (5) @(negedge clk); chk(tap(edges, 2), "R3 4096Hz");
    wait_to(t1 + 612); send(1, 4'd13); chk(1'b1, "R3 timer halted by fixed select");
    // R4: pin-style selection halts timer
    wait_to(t1 + 700); send(0, 4'd5);
    repeat (9) @(negedge clk); chk(tap(edges, 6), "R4 256Hz");
    wait_to(t1 + 1300); send(1, 4'd13); chk(1'b1, "R4 timer halted by pin-style select");

    // R10: ignored codes
    align(); send(1, 4'd8); t1 = next_tick(edges);
    send(1, 4'd2); send(1, 4'd15); send(1, 4'd0); send(1, 4'd3); send(0, 4'd7);
    chk(1'b0, "R10 output unchanged");
    wait_to(t1 - 1);   chk(1'b0, "R10 low");
    wait_to(t1);       chk(1'b1, "R10 timing unchanged rise");
    wait_to(t1 + 512); chk(1'b0, "R10 timing unchanged fall");

    // R11: hold restores 64 Hz after test code
    send(1, 4'd15); send(0, 4'd0);
    chk(tap(edges, 8), "R11 64Hz after hold");
    repeat (333) @(negedge clk); chk(tap(edges, 8), "R11 64Hz later");

    summary();
    $finish;
  end
endmodule